// File: doc/BRIEF.md
# Control Unit Reset Sequencer

This block runs the reset sequences of a control unit that sits on a host channel and serves several attached devices. It handles two kinds of request. A unit-wide reset wipes the control unit and every attached device, and throws away all pending status and interrupts. A device reset wipes only the device that is in operation when the request arrives. Both kinds run for a fixed, parameterised window. While the window is open, the unit is busy, device polling is held off, and any channel selection is refused. The refusal returns a status byte with Busy and Status Modifier set, which is the control-unit-busy answer.

When the window closes, polling resumes. The block may also raise a one-cycle request that asks the channel logic to present an asynchronous Control Unit End. A unit-wide reset always raises this request. A device reset raises it only when a selection was refused during its window.

The block keeps a registered copy of the per-device ready flags. Neither reset type changes or clears that copy, so the ready and not-ready state of the devices survives every reset.

Top module: `cu_reset_seq`

## Requirements
- R1: When a unit reset request (`unit_rst_req`) is sampled, the next cycle shows `dev_clear` with every bit set and a one-cycle `unit_clear` pulse that discards all outstanding status and interrupts.
- R2: When a device reset request is sampled while the unit is idle and no unit reset request is present, the next cycle shows a one-cycle `dev_clear` with only bit `active_dev` set, and `unit_clear` stays low.
- R3: `busy` rises in the cycle after an accepted request and stays high for exactly `RESET_CYCLES` cycles (16 by default). `poll_en` is low exactly while `busy` is high.
- R4: A `sel_strobe` sampled while `busy` is high gives, one cycle later, `resp_valid` high with `resp_status` = 8'h50 (bit 6 Status Modifier, bit 4 Busy). A strobe sampled while idle gives no response, and `resp_status` reads 0 whenever `resp_valid` is low.
- R5: When a unit reset completes, `cue_req` pulses for one cycle, namely the first cycle in which `busy` is low.
- R6: When a device reset completes, `cue_req` pulses in that same cycle only if at least one selection was refused during its window, including a refusal in the last busy cycle. Otherwise it stays low.
- R7: A unit reset request takes priority over a device reset request in the same cycle. Arriving during any running reset, it turns the sequence into a unit reset and restarts the full window.
- R8: A device reset request sampled while a reset is running is ignored: no `dev_clear` pulse, and the window is neither extended nor restarted.
- R9: `ready_hold` equals `dev_ready` from the previous cycle in all cycles, including during and after resets of either type.
- R10: While `rst_n` is low, all outputs are 0 except `poll_en`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| unit_rst_req | input | 1 | Request a reset of the unit and all devices |
| dev_rst_req | input | 1 | Request a reset of the device in operation |
| active_dev | input | DEV_W | Number of the device currently in operation |
| sel_strobe | input | 1 | Channel selection attempt, one per cycle |
| dev_ready | input | NUM_DEV | Per-device ready flags |
| dev_clear | output | NUM_DEV | One-cycle per-device clear strobes |
| unit_clear | output | 1 | One-cycle strobe discarding all unit status and interrupts |
| busy | output | 1 | Reset window open |
| poll_en | output | 1 | Device polling permitted |
| cue_req | output | 1 | One-cycle asynchronous Control Unit End request |
| resp_valid | output | 1 | A refusal status is being returned |
| resp_status | output | 8 | Status byte returned with `resp_valid` |
| ready_hold | output | NUM_DEV | Registered ready flags, kept through resets |

## Verification
A wrong mode register would show up as a wrong `cue_req` at the close of a device reset, or as a full `dev_clear` where a single bit was due. Both errors are visible one cycle after the request, or on the first idle cycle. A wrong window counter shifts the falling edge of `busy` and `poll_en`, and the per-cycle reference catches that in the exact cycle it happens. A refusal flag that is lost or set by mistake appears only at completion, so the stimulus places refusals early in a window, in the last busy cycle, and in windows that are later restarted.

// File: rtl/cu_rst_pkg.sv
package cu_rst_pkg;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_UNIT = 2'd1,
        RS_DEV  = 2'd2
    } rs_mode_e;

    // channel status byte bits
    localparam logic [7:0] ST_MODIFIER = 8'h40;
    localparam logic [7:0] ST_BUSY     = 8'h10;
    localparam logic [7:0] ST_CU_BUSY  = ST_MODIFIER | ST_BUSY;

endpackage

// File: rtl/cu_rst_timer.sv
module cu_rst_timer #(
    parameter int CYCLES = 16,
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic running,
    output logic expire
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        if (load) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = LAST;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.run = 1'b0;
                expire    = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign running = tmr_q.run;

endmodule

// File: rtl/cu_rst_target.sv
module cu_rst_target #(
    parameter int NUM_DEV = 8,
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               all_en,
    input  logic               one_en,
    input  logic [DEV_W-1:0]   dev_idx,
    output logic [NUM_DEV-1:0] clr_vec
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        assign clr_vec[g] = all_en | (one_en & (dev_idx == DEV_W'(g)));
    end

endmodule

// File: rtl/cu_reset_seq.sv
module cu_reset_seq
    import cu_rst_pkg::*;
#(
    parameter int NUM_DEV      = 8,
    parameter int RESET_CYCLES = 16,
    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unit_rst_req,
    input  logic               dev_rst_req,
    input  logic [DEV_W-1:0]   active_dev,
    input  logic               sel_strobe,
    input  logic [NUM_DEV-1:0] dev_ready,
    output logic [NUM_DEV-1:0] dev_clear,
    output logic               unit_clear,
    output logic               busy,
    output logic               poll_en,
    output logic               cue_req,
    output logic               resp_valid,
    output logic [7:0]         resp_status,
    output logic [NUM_DEV-1:0] ready_hold
);

    typedef struct packed {
        rs_mode_e           mode;
        logic               refused;
        logic [NUM_DEV-1:0] clr;
        logic               uclr;
        logic               cue;
        logic               rvalid;
        logic [7:0]         rstat;
        logic [NUM_DEV-1:0] rdy;
    } seq_t;

    seq_t st_d, st_q;

    logic               start_unit, start_dev, tmr_load;
    logic               tmr_running, tmr_expire;
    logic [NUM_DEV-1:0] clr_vec;

    assign busy       = (st_q.mode != RS_IDLE);
    assign start_unit = unit_rst_req;
    assign start_dev  = dev_rst_req & ~unit_rst_req & ~busy;
    assign tmr_load   = start_unit | start_dev;

    cu_rst_timer #(.CYCLES(RESET_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .running (tmr_running),
        .expire  (tmr_expire)
    );

    cu_rst_target #(.NUM_DEV(NUM_DEV)) u_target (
        .all_en  (start_unit),
        .one_en  (start_dev),
        .dev_idx (active_dev),
        .clr_vec (clr_vec)
    );

    always_comb begin
        st_d        = st_q;
        st_d.clr    = clr_vec;
        st_d.uclr   = start_unit;
        st_d.cue    = 1'b0;
        st_d.rvalid = sel_strobe & busy;
        st_d.rstat  = (sel_strobe & busy) ? ST_CU_BUSY : 8'h00;
        st_d.rdy    = dev_ready;
        if (start_unit) begin
            st_d.mode    = RS_UNIT;
            st_d.refused = 1'b0;
        end else if (start_dev) begin
            st_d.mode    = RS_DEV;
            st_d.refused = 1'b0;
        end else if (busy) begin
            if (sel_strobe) st_d.refused = 1'b1;
            if (tmr_expire) begin
                st_d.mode    = RS_IDLE;
                st_d.cue     = (st_q.mode == RS_UNIT) | st_q.refused | sel_strobe;
                st_d.refused = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: RS_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign dev_clear   = st_q.clr;
    assign unit_clear  = st_q.uclr;
    assign poll_en     = ~busy;
    assign cue_req     = st_q.cue;
    assign resp_valid  = st_q.rvalid;
    assign resp_status = st_q.rstat;
    assign ready_hold  = st_q.rdy;

endmodule

// File: rtl/cu_reset_seq_chk.sv
module cu_reset_seq_chk #(
    parameter int NUM_DEV      = 8,
    parameter int RESET_CYCLES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               unit_rst_req,
    input logic               sel_strobe,
    input logic [NUM_DEV-1:0] dev_clear,
    input logic               unit_clear,
    input logic               busy,
    input logic               cue_req,
    input logic               resp_valid,
    input logic [7:0]         resp_status,
    input logic               tmr_running,
    input logic               tmr_load
);

    int   win_q;
    logic unit_flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q       <= 0;
            unit_flag_q <= 1'b0;
        end else begin
            if (tmr_load)  win_q <= 0;
            else if (busy) win_q <= win_q + 1;
            if (tmr_load)  unit_flag_q <= unit_rst_req;
        end
    end

    assert_unit_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
        unit_clear |-> (&dev_clear));

    assert_dev_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_clear != '0) && !unit_clear) |-> ($countones(dev_clear) == 1));

    assert_window_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (win_q == RESET_CYCLES));

    assert_timer_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy == tmr_running);

    assert_refuse_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_strobe) |=> (resp_valid && resp_status == 8'h50));

    assert_idle_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sel_strobe) |=> !resp_valid);

    assert_cue_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cue_req |-> ($past(busy) && !busy));

    assert_unit_cue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && unit_flag_q) |-> cue_req);

endmodule

bind cu_reset_seq cu_reset_seq_chk #(
    .NUM_DEV      (NUM_DEV),
    .RESET_CYCLES (RESET_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .unit_rst_req (unit_rst_req),
    .sel_strobe   (sel_strobe),
    .dev_clear    (dev_clear),
    .unit_clear   (unit_clear),
    .busy         (busy),
    .cue_req      (cue_req),
    .resp_valid   (resp_valid),
    .resp_status  (resp_status),
    .tmr_running  (tmr_running),
    .tmr_load     (tmr_load)
);

// File: tb/test_cu_reset_seq.sv
module test_cu_reset_seq;

    localparam int N  = 8;
    localparam int RC = 16;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          unit_rst_req = 1'b0, dev_rst_req = 1'b0, sel_strobe = 1'b0;
    logic [DW-1:0] active_dev = '0;
    logic [N-1:0]  dev_ready = 8'h5A;
    logic [N-1:0]  dev_clear, ready_hold;
    logic          unit_clear, busy, poll_en, cue_req, resp_valid;
    logic [7:0]    resp_status;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cu_reset_seq i_cu_reset_seq (
        .clk(clk), .rst_n(rst_n), .unit_rst_req(unit_rst_req),
        .dev_rst_req(dev_rst_req), .active_dev(active_dev),
        .sel_strobe(sel_strobe), .dev_ready(dev_ready),
        .dev_clear(dev_clear), .unit_clear(unit_clear), .busy(busy),
        .poll_en(poll_en), .cue_req(cue_req), .resp_valid(resp_valid),
        .resp_status(resp_status), .ready_hold(ready_hold)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at %0t: actual=%0h expected=%0h", tag, what, $time, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 unit reset, 2 device reset
    int           m_mode = 0, m_left = 0;
    bit           m_refused = 0;
    logic [N-1:0] e_clr = '0, e_rdy = '0;
    logic         e_uclr = 0, e_cue = 0, e_rv = 0;
    logic [7:0]   e_rs = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_refused = 0;
            e_clr = '0; e_rdy = '0; e_uclr = 0; e_cue = 0; e_rv = 0; e_rs = '0;
        end else begin
            e_rv  = sel_strobe && (m_mode != 0);
            e_rs  = e_rv ? 8'h50 : 8'h00;
            e_rdy = dev_ready;
            e_clr = '0; e_uclr = 0; e_cue = 0;
            if (unit_rst_req) begin
                m_mode = 1; m_left = RC; m_refused = 0; e_clr = '1; e_uclr = 1;
            end else if (m_mode == 0) begin
                if (dev_rst_req) begin
                    m_mode = 2; m_left = RC; m_refused = 0;
                    e_clr = N'(1) << active_dev;
                end
            end else begin
                if (sel_strobe) m_refused = 1;
                m_left--;
                if (m_left == 0) begin
                    e_cue  = (m_mode == 1) || m_refused;
                    m_mode = 0;
                end
            end
        end
        #5;
        chk(busy === (m_mode != 0), "R3", "busy", 32'(busy), 32'(m_mode != 0));
        chk(poll_en === (m_mode == 0), "R3", "poll_en", 32'(poll_en), 32'(m_mode == 0));
        chk(dev_clear === e_clr, (&e_clr) ? "R1" : "R2", "dev_clear", 32'(dev_clear), 32'(e_clr));
        chk(unit_clear === e_uclr, "R1", "unit_clear", 32'(unit_clear), 32'(e_uclr));
        chk(cue_req === e_cue, "R5/R6", "cue_req", 32'(cue_req), 32'(e_cue));
        chk(resp_valid === e_rv, "R4", "resp_valid", 32'(resp_valid), 32'(e_rv));
        chk(resp_status === e_rs, "R4", "resp_status", 32'(resp_status), 32'(e_rs));
        chk(ready_hold === e_rdy, "R9", "ready_hold", 32'(ready_hold), 32'(e_rdy));
    end

    // ready flags keep changing throughout, resets must not disturb the copy (R9)
    always @(negedge clk)
        dev_ready <= {dev_ready[N-2:0], dev_ready[N-1] ^ dev_ready[4]};

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit u, input bit d, input int dev, input bit s);
        @(negedge clk);
        unit_rst_req = u; dev_rst_req = d; active_dev = DW'(dev); sel_strobe = s;
        @(negedge clk);
        unit_rst_req = 0; dev_rst_req = 0; sel_strobe = 0;
    endtask

    initial begin
        idle(3);
        // R10: outputs during hardware reset
        chk(busy === 0 && poll_en === 1 && cue_req === 0 && dev_clear === '0,
            "R10", "reset state", {busy, poll_en, cue_req}, 32'b010);
        rst_n = 1;
        idle(2);
        // R4: idle selections get no answer
        pulse(0, 0, 0, 1); pulse(0, 0, 0, 1);
        // R1 R3 R4 R5: unit reset with refusals
        pulse(1, 0, 0, 0); idle(3); pulse(0, 0, 0, 1); idle(RC);
        // R6: device reset without refusal gives no CUE
        pulse(0, 1, 3, 0); idle(RC + 2);
        // R6: device reset with refusal mid-window
        pulse(0, 1, 5, 0); idle(4); pulse(0, 0, 0, 1); idle(RC);
        // R6: refusal in the very last busy cycle
        pulse(0, 1, 6, 0); idle(RC - 2); pulse(0, 0, 0, 1); idle(4);
        // R7: unit reset during device reset restarts as unit reset
        pulse(0, 1, 2, 0); idle(6); pulse(1, 0, 0, 0); idle(RC + 2);
        // R7: unit reset in the last cycle of a device window
        pulse(0, 1, 1, 0); idle(RC - 2); pulse(1, 0, 0, 0); idle(RC + 2);
        // R8: device reset request during unit reset is ignored
        pulse(1, 0, 0, 0); idle(5); pulse(0, 1, 4, 0); idle(RC);
        // R7: simultaneous requests while idle, unit wins
        pulse(1, 1, 7, 0); idle(RC + 2);
        // R2: device 0 boundary
        pulse(0, 1, 0, 1); idle(RC + 2);
        // R10: hardware reset in the middle of a window
        pulse(1, 0, 0, 0); idle(4);
        rst_n = 0; idle(2);
        chk(busy === 0 && poll_en === 1 && ready_hold === '0, "R10", "mid-window reset",
            {busy, poll_en}, 32'b01);
        rst_n = 1; idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule